// File: doc/BRIEF.md
# Pin Input Glitch Filter

This block conditions one pad input before the core sees it. The raw, asynchronous pad level is first brought into the system clock domain by a chain of flops. It then either goes straight on, or passes a pulse-rejection filter that looks at it only on a sampling strobe. The core receives the result through an output register that can also invert the level.

Software controls the block through one 32-bit configuration word, which it writes and reads on a simple bus. The word has a two-bit filter length, a three-bit strobe select, an invert flag, and pull, hysteresis and open-drain fields. The pull, hysteresis and open-drain fields only drive pads elsewhere, so here they are stored and read back. The seven strobes come from divided clocks outside the block. Both the filter length and the strobe source can be changed while the block runs.

Top module: `pin_input_conditioner`

## Requirements
- R1: After reset, the configuration word reads 0x0000_0090 (pull field in bits 4:3 = 2, bits 9:7 = 0b001, all else 0), and `core_in` is 0.
- R2: With the filter length field (bits 12:11) at 0, `core_in` follows `pad_in` with a latency of three clock edges, whatever the strobes do.
- R3: With the invert bit (bit 6) set, `core_in` is the complement of the conditioned level. With it clear, a high pad gives a 1.
- R4: With a filter length N of 1 to 3, the filtered level changes only after the synchronized input has shown the new level on N+1 consecutive selected strobes. N strobes alone leave it unchanged.
- R5: A strobe that finds the synchronized input equal to the current filtered level restarts the count, so a shorter pulse is rejected.
- R6: The strobe select field (bits 15:13) with a value k from 0 to 6 uses `div_tick[k]` as the only sampling strobe. Strobes on the other inputs have no effect.
- R7: A strobe select of 7 means no strobe. The filtered output then holds its value whatever `div_tick` does.
- R8: A write that changes the filter length or the strobe select clears the strobe count and leaves `core_in` unchanged.
- R9: Bits 3–6 and 10–15 read back as written. All other bits always read their reset value and ignore writes (so writing all ones reads 0x0000_FCF8).
- R10: The pull, hysteresis and open-drain fields (bits 4:3, 5, 10) have no effect on `core_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | 1 | Raw asynchronous pad level |
| div_tick | input | NUM_DIV (7) | One-cycle sampling strobes from the clock dividers |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| core_in | output | 1 | Conditioned level delivered to the core |

## Verification
The bench builds the block with its default parameters: seven strobe inputs, a 3-bit select and a two-flop synchronizer. The full select range is therefore in reach, both the reserved code 7 and every out-of-use strobe line. The bench drives each strobe by hand, one cycle at a time. It can then count exactly N and N+1 strobes for every filter length, break a run partway, and rewrite the configuration between two strobes to show that the count is cleared.

// File: rtl/pin_cond_pkg.sv
package pin_cond_pkg;
  localparam int CFG_W = 32;
  localparam int MODE_W = 2;
  localparam int SEL_W = 3;
  localparam logic [CFG_W-1:0] CFG_RST   = 32'h0000_0090;
  localparam logic [CFG_W-1:0] CFG_WMASK = 32'h0000_FC78;

  typedef struct packed {
    logic [SEL_W-1:0]  div_sel;
    logic [MODE_W-1:0] smode;
    logic              odrain;
    logic              inv;
    logic              hyst;
    logic [1:0]        pull;
  } pin_cfg_t;

  function automatic pin_cfg_t unpack_cfg(logic [CFG_W-1:0] w);
    pin_cfg_t c;
    c.pull    = w[4:3];
    c.hyst    = w[5];
    c.inv     = w[6];
    c.odrain  = w[10];
    c.smode   = w[12:11];
    c.div_sel = w[15:13];
    return c;
  endfunction
endpackage

// File: rtl/pin_cfg_reg.sv
module pin_cfg_reg
  import pin_cond_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output pin_cfg_t         cfg,
  output logic             cfg_chg
);
  logic [CFG_W-1:0] reg_q;
  logic [CFG_W-1:0] next_w;
  pin_cfg_t         next_c;

  assign next_w = (wdata & CFG_WMASK) | (CFG_RST & ~CFG_WMASK);
  assign next_c = unpack_cfg(next_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= CFG_RST;
      cfg_chg <= 1'b0;
    end else begin
      cfg_chg <= we && ((next_c.smode != cfg.smode) || (next_c.div_sel != cfg.div_sel));
      if (we) reg_q <= next_w;
    end
  end

  assign rdata = reg_q;
  assign cfg   = unpack_cfg(reg_q);

  // R9: the word moves only on a bus write
  assert_no_write_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(reg_q));
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter #(
  parameter int NUM_DIV = 7,
  parameter int SEL_W   = 3,
  parameter int MODE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  input  logic [NUM_DIV-1:0] div_tick,
  input  logic [MODE_W-1:0] smode,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic              cfg_chg,
  output logic              filt_out
);
  localparam int EXT_W = 1 << SEL_W;

  logic [EXT_W-1:0]  tick_ext;
  logic              strobe;
  logic              bypass;
  logic [MODE_W-1:0] cnt_q;

  always_comb begin
    tick_ext = '0;
    tick_ext[NUM_DIV-1:0] = div_tick;
  end

  assign strobe = tick_ext[div_sel];
  assign bypass = (smode == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_out <= 1'b0;
      cnt_q    <= '0;
    end else if (bypass) begin
      filt_out <= sync_in;
      cnt_q    <= '0;
    end else if (cfg_chg) begin
      cnt_q <= '0;
    end else if (strobe) begin
      if (sync_in == filt_out) begin
        cnt_q <= '0;
      end else if (cnt_q == smode) begin
        filt_out <= sync_in;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: in filter mode the level moves only on a selected strobe
  assert_move_on_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(bypass) && (filt_out != $past(filt_out))) |-> $past(strobe));

  // R4: count never passes the filter length outside a reconfiguration
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_chg && !bypass) |-> (cnt_q <= smode));

  // R7: reserved select holds the filtered level
  assert_reserved_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ((div_sel == SEL_W'(EXT_W-1)) && !bypass && (EXT_W > NUM_DIV)) |=> $stable(filt_out));

  // R8: reconfiguration clears the count
  assert_chg_clears_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> (cnt_q == '0));
endmodule

// File: rtl/pin_input_conditioner.sv
module pin_input_conditioner
  import pin_cond_pkg::*;
#(
  parameter int NUM_DIV     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pad_in,
  input  logic [NUM_DIV-1:0] div_tick,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  output logic               core_in
);
  pin_cfg_t cfg;
  logic     cfg_chg;
  logic     sync_lvl;
  logic     filt_lvl;

  pin_cfg_reg i_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg), .cfg_chg(cfg_chg)
  );

  pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(sync_lvl)
  );

  pin_glitch_filter #(.NUM_DIV(NUM_DIV), .SEL_W(SEL_W), .MODE_W(MODE_W)) i_filt (
    .clk(clk), .rst(rst), .sync_in(sync_lvl), .div_tick(div_tick),
    .smode(cfg.smode), .div_sel(cfg.div_sel), .cfg_chg(cfg_chg),
    .filt_out(filt_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) core_in <= 1'b0;
    else     core_in <= ((cfg.smode == '0) ? sync_lvl : filt_lvl) ^ cfg.inv;
  end

  // R3: with invert and bypass, the output complements the synchronized level
  assert_invert_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg.inv) && ($past(cfg.smode) == '0)) |-> (core_in == !$past(sync_lvl)));
endmodule

// File: tb/test_pin_input_conditioner.sv
module test_pin_input_conditioner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pad_in = 1'b0;
  logic [6:0]  div_tick = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        core_in;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pin_input_conditioner i_pin_input_conditioner (
    .clk(clk), .rst(rst), .pad_in(pad_in), .div_tick(div_tick),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .core_in(core_in)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle(logic lvl);
    pad_in = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic tick(int k);
    div_tick = 7'(1 << k);
    @(negedge clk);
    div_tick = '0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] cfgw(int mode, int sel, bit inv);
    return 32'h10 | (32'(mode) << 11) | (32'(sel) << 13) | (32'(inv) << 6);
  endfunction

  task automatic t_reset();
    chk("R1 rdata", cfg_rdata, 32'h0000_0090);
    chk("R1 core_in", 32'(core_in), 0);
  endtask

  task automatic t_bypass();
    pad_in = 1'b1;
    div_tick = '0;
    @(negedge clk); @(negedge clk);
    chk("R2 before latency", 32'(core_in), 0);
    @(negedge clk);
    chk("R2 after latency", 32'(core_in), 1);
    settle(1'b0);
    chk("R2 low", 32'(core_in), 0);
  endtask

  task automatic t_invert();
    wr(cfgw(0, 0, 1));
    chk("R3 low pad inverted", 32'(core_in), 1);
    settle(1'b1);
    chk("R3 high pad inverted", 32'(core_in), 0);
    wr(cfgw(0, 0, 0));
    chk("R3 high pad plain", 32'(core_in), 1);
    settle(1'b0);
  endtask

  task automatic t_pad_only();
    wr(32'h0000_0438);
    chk("R10 readback", cfg_rdata, 32'h0000_04B8);
    settle(1'b1);
    chk("R10 follows high", 32'(core_in), 1);
    settle(1'b0);
    chk("R10 follows low", 32'(core_in), 0);
    wr(cfgw(0, 0, 0));
  endtask

  task automatic t_lengths();
    for (int n = 1; n <= 3; n++) begin
      wr(cfgw(n, 0, 0));
      settle(1'b1);
      for (int i = 0; i < n; i++) tick(0);
      chk($sformatf("R4 N=%0d after N strobes", n), 32'(core_in), 0);
      tick(0);
      chk($sformatf("R4 N=%0d after N+1 strobes", n), 32'(core_in), 1);
      settle(1'b0);
      for (int i = 0; i <= n; i++) tick(0);
      chk($sformatf("R4 N=%0d back low", n), 32'(core_in), 0);
    end
  endtask

  task automatic t_restart();
    wr(cfgw(2, 0, 0));
    settle(1'b1);
    tick(0); tick(0);
    settle(1'b0);
    tick(0);
    settle(1'b1);
    tick(0); tick(0);
    chk("R5 broken run rejected", 32'(core_in), 0);
    tick(0);
    chk("R5 fresh run accepted", 32'(core_in), 1);
    settle(1'b0);
    tick(0); tick(0); tick(0);
  endtask

  task automatic t_select();
    wr(cfgw(1, 4, 0));
    settle(1'b1);
    for (int k = 0; k < 7; k++) if (k != 4) begin tick(k); tick(k); end
    chk("R6 other strobes ignored", 32'(core_in), 0);
    tick(4); tick(4);
    chk("R6 selected strobe", 32'(core_in), 1);
    settle(1'b0);
    tick(4); tick(4);
  endtask

  task automatic t_reserved();
    wr(cfgw(1, 7, 0));
    settle(1'b1);
    for (int k = 0; k < 7; k++) begin tick(k); tick(k); end
    div_tick = 7'h7F;
    repeat (4) @(negedge clk);
    div_tick = '0;
    @(negedge clk);
    chk("R7 reserved select holds", 32'(core_in), 0);
    wr(cfgw(1, 0, 0));
    chk("R8 select change keeps output", 32'(core_in), 0);
    tick(0); tick(0);
    chk("R7 leaving reserved select", 32'(core_in), 1);
    settle(1'b0);
    tick(0); tick(0);
  endtask

  task automatic t_clear();
    wr(cfgw(3, 0, 0));
    settle(1'b1);
    tick(0); tick(0); tick(0);
    wr(cfgw(3, 1, 0));
    chk("R8 output unchanged", 32'(core_in), 0);
    wr(cfgw(3, 0, 0));
    tick(0);
    chk("R8 count cleared", 32'(core_in), 0);
    tick(0); tick(0); tick(0);
    chk("R8 full run after clear", 32'(core_in), 1);
  endtask

  task automatic t_rsvd_bits();
    wr(32'hFFFF_FFFF);
    chk("R9 all ones", cfg_rdata, 32'h0000_FCF8);
    wr(32'h0000_0000);
    chk("R9 all zeros", cfg_rdata, 32'h0000_0080);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_invert();
    t_pad_only();
    t_lengths();
    t_restart();
    t_select();
    t_reserved();
    t_clear();
    t_rsvd_bits();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule